// File: doc/BRIEF.md
# Ethernet Transmit Frame FIFO

This block buffers outgoing Ethernet frames between a host and a MAC transmit path. The host pushes 32-bit words into a 2048-byte store through a valid/ready word port. The low half of the first word of every frame is a payload length. That length does not count the 14-byte header. The block compares the number of stored bytes with what that length implies. It then starts sending in one of two ways. The first is automatic: the frame is complete and a programmable fill level is reached, both together. The second is explicit: the host requests a send through a register write.

The outgoing frame is a byte stream with valid/ready, start and last markers. It begins two bytes into the store, so the length field never leaves the block. While a frame is streaming, the input port holds `s_ready` low. The sink may hold `m_ready` low on any cycle. The byte and its markers then stay put until the byte is taken. Short frames can be zero-padded to the 60-byte minimum. Two sticky flags report a rejected length and a finished send. Each is cleared by an acknowledge write. Acknowledging the error flag also throws away any partly written frame.

Register writes use `reg_wr`, `reg_sel` and `reg_wdata`:
- `reg_sel` = 0 is the control register: bit 1 enables padding and bit 2 enables automatic CRC.
- `reg_sel` = 1 is the threshold register, in bits 5:0.
- `reg_sel` = 2 is the send request, in bit 0.
- `reg_sel` = 3 is the acknowledge register: bit 0 clears the error flag and bit 1 clears the empty flag.

Top module: `eth_tx_frame_fifo`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid`, `tx_err` and `tx_empty` are 0. The threshold register holds 63 and the control register holds 0.
- R2: While the store is empty, a word whose bits 15:0 exceed 2032 is dropped and sets `tx_err`. A length of exactly 2032 is accepted and leaves `tx_err` at 0.
- R3: Each stored word occupies four consecutive byte slots, bits 7:0 first. The emitted frame starts at slot 2, so its first byte is bits 23:16 of the length word.
- R4: A frame is complete when the stored byte count is at least the payload length plus 16. Add 4 more when control bit 2 (automatic CRC) is 0. The requirement is capped at 2048.
- R5: The fill level is reached when the threshold value T is below 63 and the stored count is at least 4·(8·T+1); T = 63 disables it. An accepted word that leaves both the fill level reached and the frame complete starts a send on the following cycle. No send starts otherwise.
- R6: Writing 1 to bit 0 of register 2 starts a send regardless of threshold or completeness.
- R7: The emitted length is the payload length plus 14, capped at 2046. `m_first` marks only the first byte and `m_last` marks only the final byte.
- R8: With control bit 1 set and an emitted length below 60, the frame is extended to 60 bytes. The added bytes are zero.
- R9: When the last byte is taken, the stored count returns to zero and `tx_empty` is set.
- R10: Writing register 3 with bit 0 set clears `tx_err` and empties the store. Writing it with bit 1 set clears `tx_empty`.
- R11: While `m_valid` is 1 and `m_ready` is 0, `m_data`, `m_first` and `m_last` hold their values into the next cycle.
- R12: `s_ready` is 0 while a frame is being streamed. A word offered with fewer than four free bytes left is dropped without changing the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Host word offered |
| s_ready | output | 1 | Block accepts a word this cycle |
| s_word | input | 32 | Host data word |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 threshold, 2 send request, 3 acknowledge |
| reg_wdata | input | 32 | Register write data |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Sink takes the byte |
| m_data | output | 8 | Output byte |
| m_first | output | 1 | First byte of the frame |
| m_last | output | 1 | Final byte of the frame |
| tx_err | output | 1 | Sticky: a length word was rejected |
| tx_empty | output | 1 | Sticky: a frame finished sending |

## Verification
The embedded properties watch the following on every cycle:
- the sink stall hold (R11);
- the bound and alignment of the byte count;
- that the store does not change during a send (R12);
- that a send start is followed by streaming;
- the range of the latched frame length (R7, R8);
- the raising of both flags (R2, R9).

Some things only the directed scenarios can show, by comparing whole frames with values worked out from the requirements:
- the byte order and the two-byte offset;
- the point at which completeness and the fill level meet for each CRC setting and threshold;
- the zero padding;
- that an error acknowledge discards a partial frame;
- that a word offered to a full store is dropped.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;
  localparam int WORD_BYTES   = 4;
  localparam int LEN_W        = 16;
  localparam int MAX_PAYLOAD  = 2032;
  localparam int HDR_BYTES    = 14;
  localparam int LEN_FIELD    = 2;
  localparam int CRC_BYTES    = 4;
  localparam int MIN_FRAME    = 60;
  localparam int THR_W        = 6;
  localparam int THR_OFF      = 63;
  localparam int THR_STEP     = 8;
  localparam int CTL_PAD_BIT  = 1;
  localparam int CTL_CRC_BIT  = 2;
  localparam int ACK_ERR_BIT  = 0;
  localparam int ACK_EMP_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_THR  = 2'd1,
    SEL_SEND = 2'd2,
    SEL_ACK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/eth_txf_buffer.sv
module eth_txf_buffer
  import eth_txf_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1),
  parameter int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_word,
  input  logic              clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic [CNT_W-1:0]  count
);
  localparam int NWORDS = BUF_BYTES / WORD_BYTES;
  localparam int WIDX_W = $clog2(NWORDS);

  logic [31:0]       mem [NWORDS];
  logic              has_room;
  logic [31:0]       rd_word;
  logic [WIDX_W-1:0] wr_idx;

  assign has_room = (count <= CNT_W'(BUF_BYTES - WORD_BYTES));
  assign wr_idx   = count[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (wr_en && has_room && !clr) mem[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (wr_en && has_room) count <= count + CNT_W'(WORD_BYTES);
  end

  assign rd_word = mem[rd_addr[ADDR_W-1:2]];
  assign rd_byte = rd_word[{rd_addr[1:0], 3'b000} +: 8];

  // R12: the count stays word aligned and within the store
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CNT_W'(BUF_BYTES)) && (count[1:0] == 2'b00));

  // R12: a word offered with no room leaves the count alone
  p_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && count > CNT_W'(BUF_BYTES - WORD_BYTES)) |=> $stable(count));
endmodule

// File: rtl/eth_txf_ctrl.sv
module eth_txf_ctrl
  import eth_txf_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_fire,
  input  logic [LEN_W-1:0] data_lo,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [THR_W-1:0] reg_bits,
  input  logic [CNT_W-1:0] count,
  input  logic             busy,
  input  logic             done,
  output logic             store_en,
  output logic             buf_clr,
  output logic             start,
  output logic [LEN_W-1:0] pay_len,
  output logic             pad_en,
  output logic             tx_err,
  output logic             tx_empty
);
  localparam int SUM_W = LEN_W + 1;

  logic [THR_W-1:0] thr_q;
  logic             crc_q;
  logic             pend_q;
  logic             first_word, too_long;
  logic             wr_ctrl, wr_thr, wr_send, wr_ack;
  logic [SUM_W-1:0] need_raw, need, thr_lim;
  logic             complete, thr_hit, auto_go, force_go;

  assign first_word = (count == '0);
  assign too_long   = first_word && (data_lo > LEN_W'(MAX_PAYLOAD));
  assign store_en   = data_fire && !too_long;

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_thr  = reg_wr && (reg_sel == SEL_THR);
  assign wr_send = reg_wr && (reg_sel == SEL_SEND);
  assign wr_ack  = reg_wr && (reg_sel == SEL_ACK);

  always_comb begin
    need_raw = {1'b0, pay_len} + SUM_W'(LEN_FIELD + HDR_BYTES);
    if (!crc_q) need_raw = need_raw + SUM_W'(CRC_BYTES);
    need = (need_raw > SUM_W'(BUF_BYTES)) ? SUM_W'(BUF_BYTES) : need_raw;
  end

  assign complete = (SUM_W'(count) >= need);
  assign thr_lim  = (SUM_W'(thr_q) * SUM_W'(THR_STEP) + SUM_W'(1)) * SUM_W'(WORD_BYTES);
  assign thr_hit  = (thr_q != THR_W'(THR_OFF)) && (SUM_W'(count) >= thr_lim);

  assign auto_go  = pend_q && thr_hit && complete && !busy;
  assign force_go = wr_send && reg_bits[0] && !busy;
  assign start    = auto_go || force_go;
  assign buf_clr  = done || (wr_ack && reg_bits[ACK_ERR_BIT] && !busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q   <= THR_W'(THR_OFF);
      pad_en  <= 1'b0;
      crc_q   <= 1'b0;
      pend_q  <= 1'b0;
      pay_len <= '0;
    end else begin
      pend_q <= store_en;
      if (wr_ctrl) begin
        pad_en <= reg_bits[CTL_PAD_BIT];
        crc_q  <= reg_bits[CTL_CRC_BIT];
      end
      if (wr_thr) thr_q <= reg_bits;
      if (store_en && first_word) pay_len <= data_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_err   <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      if (data_fire && too_long)               tx_err <= 1'b1;
      else if (wr_ack && reg_bits[ACK_ERR_BIT]) tx_err <= 1'b0;
      if (done)                                tx_empty <= 1'b1;
      else if (wr_ack && reg_bits[ACK_EMP_BIT]) tx_empty <= 1'b0;
    end
  end

  // R2: a rejected length word raises the error flag and stores nothing
  p_err_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && count == '0 && data_lo > LEN_W'(MAX_PAYLOAD)) |=> (tx_err && count == '0));

  // R9: the end of a send empties the store and sets the empty flag
  p_empty_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (tx_empty && count == '0));

  // R5: a start is always followed by streaming
  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/eth_txf_streamer.sv
module eth_txf_streamer
  import eth_txf_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1),
  parameter int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              pad_en,
  input  logic [7:0]        rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [7:0]        m_data,
  output logic              m_first,
  output logic              m_last
);
  localparam int SUM_W    = LEN_W + 1;
  localparam int MAX_EMIT = BUF_BYTES - LEN_FIELD;

  logic [CNT_W-1:0] idx, frame_len, data_end;
  logic [SUM_W-1:0] raw, capped, padded;
  logic             pad_q;
  logic             fire;

  always_comb begin
    raw    = {1'b0, pay_len} + SUM_W'(HDR_BYTES);
    capped = (raw > SUM_W'(MAX_EMIT)) ? SUM_W'(MAX_EMIT) : raw;
    padded = (pad_en && capped < SUM_W'(MIN_FRAME)) ? SUM_W'(MIN_FRAME) : capped;
  end

  assign m_valid = busy;
  assign fire    = busy && m_ready;
  assign m_first = busy && (idx == '0);
  assign m_last  = busy && (idx == frame_len - CNT_W'(1));
  assign done    = fire && m_last;
  assign rd_addr = ADDR_W'(idx + CNT_W'(LEN_FIELD));
  assign m_data  = (idx < data_end) ? rd_byte : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      frame_len <= '0;
      data_end  <= '0;
      pad_q     <= 1'b0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      idx       <= '0;
      frame_len <= CNT_W'(padded);
      data_end  <= CNT_W'(capped);
      pad_q     <= pad_en;
    end else if (fire) begin
      idx <= idx + CNT_W'(1);
      if (m_last) busy <= 1'b0;
    end
  end

  // R11: a stalled byte and its markers hold
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first) && $stable(m_last)));

  // R7: the latched emitted length stays within header and store limits
  p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (frame_len >= CNT_W'(HDR_BYTES) && frame_len <= CNT_W'(MAX_EMIT)));

  // R8: a padded frame is never shorter than the minimum
  p_pad_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pad_q) |-> (frame_len >= CNT_W'(MIN_FRAME)));
endmodule

// File: rtl/eth_tx_frame_fifo.sv
module eth_tx_frame_fifo
  import eth_txf_pkg::*;
#(
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_word,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  output logic        m_first,
  output logic        m_last,
  output logic        tx_err,
  output logic        tx_empty
);
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int ADDR_W = $clog2(BUF_BYTES);

  logic              data_fire, store_en, buf_clr, start, busy, done, pad_en;
  logic [CNT_W-1:0]  count;
  logic [LEN_W-1:0]  pay_len;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_byte;
  logic              unused_bits;

  assign unused_bits = ^reg_wdata[31:THR_W];
  assign s_ready     = !busy && !start;
  assign data_fire   = s_valid && s_ready;

  eth_txf_buffer #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_en),
    .wr_word (s_word),
    .clr     (buf_clr),
    .rd_addr (rd_addr),
    .rd_byte (rd_byte),
    .count   (count)
  );

  eth_txf_ctrl #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_fire (data_fire),
    .data_lo   (s_word[LEN_W-1:0]),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_bits  (reg_wdata[THR_W-1:0]),
    .count     (count),
    .busy      (busy),
    .done      (done),
    .store_en  (store_en),
    .buf_clr   (buf_clr),
    .start     (start),
    .pay_len   (pay_len),
    .pad_en    (pad_en),
    .tx_err    (tx_err),
    .tx_empty  (tx_empty)
  );

  eth_txf_streamer #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_str (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .pay_len (pay_len),
    .pad_en  (pad_en),
    .rd_byte (rd_byte),
    .rd_addr (rd_addr),
    .busy    (busy),
    .done    (done),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_first (m_first),
    .m_last  (m_last)
  );

  // R12: the store does not change while a frame streams, until its last byte
  p_store_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !(m_ready && m_last)) |=> $stable(count));
endmodule

// File: tb/eth_tx_frame_fifo_bench.sv
`timescale 1ns/1ps
module eth_tx_frame_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_word = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data;
  logic        m_first, m_last, tx_err, tx_empty;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eth_tx_frame_fifo u_eth_tx_frame_fifo (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_word(s_word),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_first(m_first),
    .m_last(m_last), .tx_err(tx_err), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] mkword(input int k, input int len);
    if (k == 0) return {8'h03, 8'h02, len[15:0]};
    return {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
  endfunction

  // all tasks start and end at a falling edge
  task automatic put_word(input logic [31:0] w);
    s_valid = 1'b1;
    s_word  = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic put_frame(input int len, input int first_k, input int nwords);
    for (int k = first_k; k < first_k + nwords; k++) put_word(mkword(k, len));
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic expect_idle(input string req);
    bit seen = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (m_valid) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  // receives one frame; bytes below data_n follow the slot pattern, the rest are zero
  task automatic collect(input int exp_len, input int data_n, input bit stall, input string req);
    int n = 0, bad_bytes = 0, first_bad = -1, wc = 0, bad_mark = 0, ready_hi = 0;
    int act_at = 0, exp_at = 0;
    bit got_last = 0;
    while (!m_valid && wc < 60) begin @(negedge clk); wc++; end
    check(m_valid, {req, " frame started"}, m_valid, 1);
    while (!got_last && n < 2100 && m_valid) begin
      m_ready = stall ? ((n % 3) != 1 || wc[0]) : 1'b1;
      wc++;
      if (s_ready) ready_hi++;
      if (m_ready) begin
        int expv = (n < data_n) ? ((2 + n) & 255) : 0;
        if (m_data != 8'(expv)) begin
          bad_bytes++;
          if (first_bad < 0) begin first_bad = n; act_at = m_data; exp_at = expv; end
        end
        if (m_first != (n == 0)) bad_mark++;
        if (m_last) got_last = 1;
        if (m_last != (n == exp_len - 1)) bad_mark++;
        n++;
      end
      @(negedge clk);
    end
    m_ready = 1'b1;
    check(n == exp_len, "R7 emitted length", n, exp_len);
    check(bad_mark == 0, "R7 start/last markers", bad_mark, 0);
    check(bad_bytes == 0, {req, " byte content (R3 order, R8 pad)"}, act_at, exp_at);
    check(ready_hi == 0, "R12 input stalled during send", ready_hi, 0);
    check(tx_empty, "R9 empty flag after send", tx_empty, 1);
    reg_write(SEL_ACK_C, 32'h2);
    check(!tx_empty, "R10 empty flag acknowledge", tx_empty, 0);
  endtask

  localparam logic [1:0] SEL_CTRL_C = 2'd0, SEL_THR_C = 2'd1, SEL_SEND_C = 2'd2, SEL_ACK_C = 2'd3;

  task automatic t_reset();
    check(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
    check(m_valid == 1'b0, "R1 m_valid", m_valid, 0);
    check(tx_err == 1'b0 && tx_empty == 1'b0, "R1 flags", {tx_err, tx_empty}, 0);
  endtask

  task automatic t_forced();
    put_frame(20, 0, 9);
    expect_idle("R1 R5 threshold disabled after reset");
    reg_write(SEL_SEND_C, 32'h1);
    collect(34, 34, 1'b0, "R6 forced send");
  endtask

  task automatic t_pad();
    reg_write(SEL_CTRL_C, 32'h2);
    put_frame(10, 0, 7);
    reg_write(SEL_SEND_C, 32'h1);
    collect(60, 24, 1'b1, "R8 padded frame");
  endtask

  task automatic t_auto_crc_on();
    reg_write(SEL_CTRL_C, 32'h4);
    reg_write(SEL_THR_C, 32'h0);
    put_frame(8, 0, 5);
    expect_idle("R4 incomplete with CRC on");
    put_frame(8, 5, 1);
    collect(22, 22, 1'b1, "R5 auto send at len+16");
  endtask

  task automatic t_auto_crc_off();
    reg_write(SEL_CTRL_C, 32'h0);
    put_frame(8, 0, 6);
    expect_idle("R4 extra four bytes with CRC off");
    put_frame(8, 6, 1);
    collect(22, 22, 1'b0, "R4 auto send at len+20");
  endtask

  task automatic t_thr_level();
    reg_write(SEL_CTRL_C, 32'h4);
    reg_write(SEL_THR_C, 32'h2);
    put_frame(8, 0, 16);
    expect_idle("R5 below fill level 68");
    put_frame(8, 16, 1);
    collect(22, 22, 1'b1, "R5 send at fill level");
  endtask

  task automatic t_len_err();
    reg_write(SEL_THR_C, 32'd63);
    put_word(mkword(0, 2033));
    check(tx_err, "R2 length above 2032 flagged", tx_err, 1);
    put_frame(8, 0, 3);
    reg_write(SEL_ACK_C, 32'h1);
    check(!tx_err, "R10 error acknowledge", tx_err, 0);
    reg_write(SEL_THR_C, 32'h0);
    put_frame(4, 0, 5);
    collect(18, 18, 1'b0, "R10 partial frame discarded");
  endtask

  task automatic t_full();
    reg_write(SEL_CTRL_C, 32'h0);
    reg_write(SEL_THR_C, 32'd63);
    put_frame(2032, 0, 512);
    put_word(32'hDEADBEEF);
    check(!tx_err, "R2 length 2032 accepted", tx_err, 0);
    reg_write(SEL_SEND_C, 32'h1);
    collect(2046, 2046, 1'b0, "R12 word dropped when full");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forced();
    t_pad();
    t_auto_crc_on();
    t_auto_crc_off();
    t_thr_level();
    t_len_err();
    t_full();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule